// File: doc/BRIEF.md
# Operate and Effective-Address Execute Unit

This block is the execute stage of a 16-bit fixed-width load/store processor. It covers the register-to-register arithmetic and logic instructions and the address-forming instruction. It takes the current instruction word and the already-incremented program counter. It decodes the 4-bit opcode and produces the destination index, the write enable, the result word and the ALU function that was selected. The result is committed into an eight-entry general-purpose register file on the next rising clock edge.

The block decodes three operations: add, bitwise and, and bitwise complement. Add and and take their second operand either from a register or from a 5-bit signed constant, and one instruction bit picks which. The address-forming instruction adds a 9-bit signed offset to the incremented program counter. It routes that sum through the ALU's pass-through function and never reads memory. Every other opcode, including a reserved one, leaves the register file untouched.

The register file sits inside the block, so the stage can be exercised on its own. A register is loaded by forming an address with a zero offset. It is read back by adding zero to it.

Top module: `opea_exec_unit`

## Requirements
- R1: A synchronous, active-high reset clears all eight registers to 0x0000. The first read of any register after reset returns zero.
- R2: Opcode 0001 is add. With bit 5 = 0 it writes R[bits 8:6] + R[bits 2:0] (modulo 2^16) to register R[bits 11:9]. Bits 4:3 are ignored, and the write enable is high.
- R3: Opcode 0001 with bit 5 = 1 writes R[bits 8:6] plus bits 4:0 sign-extended to 16 bits, so the constant ranges from -16 to +15.
- R4: Opcode 0101 is and, with the same two operand modes as R2/R3 selected by bit 5. The result is the bitwise AND.
- R5: Opcode 1001 writes the bitwise complement of R[bits 8:6] to R[bits 11:9]. Source and destination may be the same register, and bits 5:0 are ignored.
- R6: Opcode 1110 writes the incremented PC plus bits 8:0 sign-extended (range -256 to +255, modulo 2^16) to R[bits 11:9]. No register operand is used.
- R7: A write takes effect at the rising clock edge while the write enable is high. Register reads are combinational, so the very next instruction sees the new value.
- R8: Every opcode other than 0001, 0101, 1001 and 1110 drives the write enable low and changes no register. This includes the reserved opcode 1101.
- R9: The ALU function output encodes 0 = add, 1 = and, 2 = complement, 3 = pass-through. Opcode 1110 and all non-writing opcodes report pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; register writes on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Instruction word being executed |
| pc_inc_i | input | 16 | Program counter already incremented past this instruction |
| wr_en_o | output | 1 | Register write enable for this instruction |
| wr_idx_o | output | 3 | Destination register index |
| wr_data_o | output | 16 | Result word to be written |
| alu_fn_o | output | 2 | ALU function selected (see R9) |

## Verification
The bench goes after both ends of each signed field. For the 5-bit constant these are +15 and -16. For the 9-bit offset they are +255 (0x0FF) and -256 (0x100), plus an address sum that wraps past 0xFFFF. A design that zero-extends either field would produce a result off by 32 or 512. Add in register mode is driven with bits 4:3 set, so a decoder that lets those bits leak into the operand choice would read the wrong register. The bench also complements a register in place, issues a read in the cycle directly after a write, and sweeps every non-writing opcode, checking the destination afterwards. Together these catch a late or lost write, a stale combinational read, and a reserved opcode that still writes.

// File: rtl/opea_pkg.sv
package opea_pkg;

    localparam int WORD_W    = 16;
    localparam int OPC_W     = 4;
    localparam int IDX_W     = 3;
    localparam int IMM_W     = 5;
    localparam int OFF_W     = 9;
    localparam int FN_W      = 2;

    // opcode values (the decoder keys on these)
    localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;
    localparam logic [OPC_W-1:0] OPC_LEA = 4'b1110;

    typedef enum logic [FN_W-1:0] {
        FN_ADD  = 2'd0,
        FN_AND  = 2'd1,
        FN_NOT  = 2'd2,
        FN_PASS = 2'd3
    } alu_fn_e;

    // decoded control word
    typedef struct packed {
        logic             wr_en;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src_a;
        logic [IDX_W-1:0] src_b;
        logic             use_imm;
        logic             sel_ea;
        alu_fn_e          fn;
    } dec_t;

    function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic [WORD_W-1:0] sext_off(input logic [OFF_W-1:0] v);
        return {{(WORD_W-OFF_W){v[OFF_W-1]}}, v};
    endfunction

endpackage

// File: rtl/opea_decoder.sv
module opea_decoder
    import opea_pkg::*;
(
    input  logic [WORD_W-1:0] instr_i,
    output dec_t              dec_o,
    output logic [WORD_W-1:0] imm_o,
    output logic [OFF_W-1:0]  off_o
);
    logic [OPC_W-1:0] opc;

    assign opc   = instr_i[WORD_W-1 -: OPC_W];
    assign imm_o = sext_imm(instr_i[IMM_W-1:0]);
    assign off_o = instr_i[OFF_W-1:0];

    always_comb begin
        dec_o.wr_en   = 1'b0;
        dec_o.dst     = instr_i[11:9];
        dec_o.src_a   = instr_i[8:6];
        dec_o.src_b   = instr_i[2:0];
        dec_o.use_imm = 1'b0;
        dec_o.sel_ea  = 1'b0;
        dec_o.fn      = FN_PASS;
        unique case (opc)
            OPC_ADD: begin
                dec_o.wr_en   = 1'b1;
                dec_o.use_imm = instr_i[5];
                dec_o.fn      = FN_ADD;
            end
            OPC_AND: begin
                dec_o.wr_en   = 1'b1;
                dec_o.use_imm = instr_i[5];
                dec_o.fn      = FN_AND;
            end
            OPC_NOT: begin
                dec_o.wr_en   = 1'b1;
                dec_o.fn      = FN_NOT;
            end
            OPC_LEA: begin
                dec_o.wr_en   = 1'b1;
                dec_o.sel_ea  = 1'b1;
                dec_o.fn      = FN_PASS;
            end
            default: begin
                dec_o.wr_en   = 1'b0;
                dec_o.fn      = FN_PASS;
            end
        endcase
    end
endmodule

// File: rtl/opea_ea_gen.sv
module opea_ea_gen
    import opea_pkg::*;
(
    input  logic [WORD_W-1:0] pc_inc_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [WORD_W-1:0] ea_o
);
    assign ea_o = pc_inc_i + sext_off(off_i);
endmodule

// File: rtl/opea_alu.sv
module opea_alu
    import opea_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  alu_fn_e       fn_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    output logic [W-1:0]  y_o
);
    always_comb begin
        unique case (fn_i)
            FN_ADD:  y_o = a_i + b_i;
            FN_AND:  y_o = a_i & b_i;
            FN_NOT:  y_o = ~a_i;
            default: y_o = a_i;
        endcase
    end
endmodule

// File: rtl/opea_regfile.sv
module opea_regfile #(
    parameter int W     = 16,
    parameter int NREG  = 8,
    localparam int AW   = $clog2(NREG)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          we_i,
    input  logic [AW-1:0] wa_i,
    input  logic [W-1:0]  wd_i,
    input  logic [AW-1:0] ra_a_i,
    input  logic [AW-1:0] ra_b_i,
    output logic [W-1:0]  rd_a_o,
    output logic [W-1:0]  rd_b_o
);
    logic [W-1:0] q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                q[g] <= '0;
            end else if (we_i && (wa_i == AW'(g))) begin
                q[g] <= wd_i;
            end
        end
    end

    assign rd_a_o = q[ra_a_i];
    assign rd_b_o = q[ra_b_i];
endmodule

// File: rtl/opea_exec_unit.sv
module opea_exec_unit
    import opea_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [WORD_W-1:0] instr_i,
    input  logic [WORD_W-1:0] pc_inc_i,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic [FN_W-1:0]   alu_fn_o
);
    dec_t              dec;
    logic [WORD_W-1:0] imm_x;
    logic [OFF_W-1:0]  off;
    logic [WORD_W-1:0] ea;
    logic [WORD_W-1:0] rd_a, rd_b;
    logic [WORD_W-1:0] alu_a, alu_b, alu_y;

    opea_decoder u_dec (
        .instr_i (instr_i),
        .dec_o   (dec),
        .imm_o   (imm_x),
        .off_o   (off)
    );

    opea_ea_gen u_ea (
        .pc_inc_i (pc_inc_i),
        .off_i    (off),
        .ea_o     (ea)
    );

    opea_regfile #(.W(WORD_W), .NREG(NREG)) u_rf (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .we_i   (dec.wr_en),
        .wa_i   (dec.dst),
        .wd_i   (alu_y),
        .ra_a_i (dec.src_a),
        .ra_b_i (dec.src_b),
        .rd_a_o (rd_a),
        .rd_b_o (rd_b)
    );

    assign alu_a = dec.sel_ea  ? ea    : rd_a;
    assign alu_b = dec.use_imm ? imm_x : rd_b;

    opea_alu #(.W(WORD_W)) u_alu (
        .fn_i (dec.fn),
        .a_i  (alu_a),
        .b_i  (alu_b),
        .y_o  (alu_y)
    );

    assign wr_en_o   = dec.wr_en;
    assign wr_idx_o  = dec.dst;
    assign wr_data_o = alu_y;
    assign alu_fn_o  = dec.fn;
endmodule

// File: rtl/opea_exec_unit_chk.sv
module opea_exec_unit_chk
    import opea_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic [WORD_W-1:0] instr_i,
    input logic [WORD_W-1:0] pc_inc_i,
    input logic              wr_en_o,
    input logic [IDX_W-1:0]  wr_idx_o,
    input logic [WORD_W-1:0] wr_data_o,
    input logic [FN_W-1:0]   alu_fn_o
);
    logic [OPC_W-1:0] opc;
    logic             writer;
    logic             add_zero;

    assign opc      = instr_i[15:12];
    assign writer   = (opc == OPC_ADD) || (opc == OPC_AND) || (opc == OPC_NOT) || (opc == OPC_LEA);
    assign add_zero = (opc == OPC_ADD) && instr_i[5] && (instr_i[4:0] == 5'd0);

    // R8 / R9: non-writing opcodes keep the file untouched and report pass-through
    assert_no_write_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !writer |-> (!wr_en_o && alu_fn_o == 2'd3));

    // R2: destination comes from bits 11:9
    assert_dest_field_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_o |-> (wr_idx_o == instr_i[11:9]));

    // R6: address sum from incremented PC and signed offset
    assert_ea_sum_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (opc == OPC_LEA) |-> (wr_en_o && alu_fn_o == 2'd3 &&
            wr_data_o == pc_inc_i + {{7{instr_i[8]}}, instr_i[8:0]}));

    // R4: masking with a zero constant always yields zero
    assert_and_zero_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        ((opc == OPC_AND) && instr_i[5] && (instr_i[4:0] == 5'd0)) |-> (wr_data_o == '0));

    // R1: first read after reset sees zero
    assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(rst_i) && add_zero) |-> (wr_data_o == '0));

    // R7: value written last edge is read back by the next instruction
    assert_write_visible_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(wr_en_o) && add_zero && (instr_i[8:6] == $past(wr_idx_o)))
            |-> (wr_data_o == $past(wr_data_o)));
endmodule

bind opea_exec_unit opea_exec_unit_chk u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .instr_i   (instr_i),
    .pc_inc_i  (pc_inc_i),
    .wr_en_o   (wr_en_o),
    .wr_idx_o  (wr_idx_o),
    .wr_data_o (wr_data_o),
    .alu_fn_o  (alu_fn_o)
);

// File: tb/opea_exec_unit_tb.sv
module opea_exec_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] instr;
    logic [15:0] pc_inc;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [15:0] wr_data;
    logic [1:0]  alu_fn;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [15:0] model [8];

    always #2 clk = ~clk;   // 250 MHz

    opea_exec_unit u_dut (
        .clk_i     (clk),
        .rst_i     (rst),
        .instr_i   (instr),
        .pc_inc_i  (pc_inc),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data),
        .alu_fn_o  (alu_fn)
    );

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] sx5(input logic [4:0] v);
        return {{11{v[4]}}, v};
    endfunction

    function automatic logic [15:0] sx9(input logic [8:0] v);
        return {{7{v[8]}}, v};
    endfunction

    // one instruction: predict, drive, compare, commit to model
    task automatic run(input logic [15:0] ins, input logic [15:0] pc, input string tag);
        logic [3:0]  op;
        logic        e_en;
        logic [1:0]  e_fn;
        logic [15:0] e_d;
        logic [15:0] opb;
        op   = ins[15:12];
        opb  = ins[5] ? sx5(ins[4:0]) : model[ins[2:0]];
        e_en = 1'b0;
        e_fn = 2'd3;
        e_d  = 16'h0;
        case (op)
            4'b0001: begin e_en = 1'b1; e_fn = 2'd0; e_d = model[ins[8:6]] + opb; end
            4'b0101: begin e_en = 1'b1; e_fn = 2'd1; e_d = model[ins[8:6]] & opb; end
            4'b1001: begin e_en = 1'b1; e_fn = 2'd2; e_d = ~model[ins[8:6]]; end
            4'b1110: begin e_en = 1'b1; e_fn = 2'd3; e_d = pc + sx9(ins[8:0]); end
            default: begin e_en = 1'b0; e_fn = 2'd3; end
        endcase
        @(negedge clk);
        instr  = ins;
        pc_inc = pc;
        #1;
        check(tag, "wr_en", {15'h0, wr_en}, {15'h0, e_en});
        check("R9", "alu_fn", {14'h0, alu_fn}, {14'h0, e_fn});
        if (e_en) begin
            check(tag, "wr_idx", {13'h0, wr_idx}, {13'h0, ins[11:9]});
            check(tag, "wr_data", wr_data, e_d);
            model[ins[11:9]] = e_d;
        end
    endtask

    task automatic load_reg(input logic [2:0] r, input logic [15:0] v, input string tag);
        run({4'b1110, r, 9'h000}, v, tag);
    endtask

    task automatic read_reg(input logic [2:0] r, input string tag);
        run({4'b0001, r, r, 1'b1, 5'd0}, 16'h0, tag);
    endtask

    task automatic t_reset_state;
        for (int r = 0; r < 8; r++) read_reg(3'(r), "R1");
    endtask

    task automatic t_lea;
        load_reg(3'd1, 16'hBEEF, "R6");
        run({4'b1110, 3'd2, 9'h0FF}, 16'h3001, "R6");   // +255 -> 0x3100
        run({4'b1110, 3'd3, 9'h100}, 16'h3001, "R6");   // -256 -> 0x2F01
        run({4'b1110, 3'd4, 9'h020}, 16'hFFF0, "R6");   // wraps to 0x0010
        read_reg(3'd2, "R6");
        read_reg(3'd3, "R6");
    endtask

    task automatic t_add_reg;
        load_reg(3'd1, 16'h1234, "R2");
        load_reg(3'd2, 16'h0F0F, "R2");
        run({4'b0001, 3'd3, 3'd1, 1'b0, 2'b11, 3'd2}, 16'h0, "R2");   // bits 4:3 set
        load_reg(3'd5, 16'h8000, "R2");
        run({4'b0001, 3'd6, 3'd5, 1'b0, 2'b10, 3'd5}, 16'h0, "R2");   // 0x8000+0x8000
    endtask

    task automatic t_add_imm;
        load_reg(3'd5, 16'h0010, "R3");
        run({4'b0001, 3'd6, 3'd5, 1'b1, 5'h0F}, 16'h0, "R3");   // +15
        run({4'b0001, 3'd6, 3'd5, 1'b1, 5'h10}, 16'h0, "R3");   // -16
        run({4'b0001, 3'd7, 3'd6, 1'b1, 5'h1F}, 16'h0, "R3");   // 0 - 1
    endtask

    task automatic t_and;
        load_reg(3'd1, 16'hF0F3, "R4");
        load_reg(3'd2, 16'h3C3C, "R4");
        run({4'b0101, 3'd3, 3'd1, 1'b0, 2'b01, 3'd2}, 16'h0, "R4");
        run({4'b0101, 3'd4, 3'd1, 1'b1, 5'h10}, 16'h0, "R4");   // mask 0xFFF0
        run({4'b0101, 3'd4, 3'd1, 1'b1, 5'h07}, 16'h0, "R4");   // mask 0x0007
    endtask

    task automatic t_not;
        load_reg(3'd6, 16'h5A0F, "R5");
        run({4'b1001, 3'd6, 3'd6, 6'h3F}, 16'h0, "R5");
        run({4'b1001, 3'd6, 3'd6, 6'h00}, 16'h0, "R5");
        run({4'b1001, 3'd0, 3'd6, 6'h15}, 16'h0, "R5");
    endtask

    task automatic t_back_to_back;
        load_reg(3'd0, 16'hA5A5, "R7");
        run({4'b0001, 3'd7, 3'd0, 1'b1, 5'h01}, 16'h0, "R7");
        run({4'b0001, 3'd7, 3'd7, 1'b0, 2'b00, 3'd7}, 16'h0, "R7");
        read_reg(3'd7, "R7");
    endtask

    task automatic t_reserved;
        logic [3:0] ops [12];
        ops = '{4'b0000, 4'b0010, 4'b0011, 4'b0100, 4'b0110, 4'b0111,
                4'b1000, 4'b1010, 4'b1011, 4'b1100, 4'b1101, 4'b1111};
        load_reg(3'd4, 16'h7E57, "R8");
        for (int i = 0; i < 12; i++) begin
            run({ops[i], 3'd4, 9'h1A5}, 16'h1111, "R8");
            read_reg(3'd4, "R8");
        end
    endtask

    initial begin
        for (int r = 0; r < 8; r++) model[r] = 16'h0;
        rst    = 1'b1;
        instr  = 16'h0;
        pc_inc = 16'h0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_lea();
        t_add_reg();
        t_add_imm();
        t_and();
        t_not();
        t_back_to_back();
        t_reserved();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            fails++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule